// File: doc/BRIEF.md
# Receive Descriptor DMA Controller

This block sequences the receive side of a descriptor-ring Ethernet DMA. It fetches one descriptor at a time through a request/response port and reads the ownership flag in the descriptor's first word. When the DMA owns the descriptor, the engine hands the buffer to the MAC for an arriving frame. When the host owns it, the engine parks in a suspended state. The engine keeps a list pointer that walks the ring by a fixed stride and wraps to the list base on a descriptor marked as the ring's last entry.

Software drives a run bit and a poll-demand pulse, reads a two-bit process state, and clears two sticky status flags with write-one-to-clear pulses. The first flag reports that no buffer was available. The second reports that the process stopped. A stop completes only after the MAC receiver enable has been dropped.

Top module: `rxd_engine`

## Requirements
- R1: After reset, `proc_state` is 0 (stopped), `cur_ptr` is 0, both flags are low and `fetch_req` is low. `proc_state` is 0 when stopped, 1 when running and 2 when suspended, and never 3.
- R2: A high `run_en` in the stopped state loads `cur_ptr` from `list_base` and fetches the descriptor at that address. `fetch_req` stays high with a stable `fetch_addr` until `fetch_ack`. In `fetch_data`, bit 31 set means the DMA owns the descriptor.
- R3: A fetch made while running that returns a host-owned descriptor moves the engine to suspended and sets `flag_ru`. Failed re-fetches while already suspended never set `flag_ru`.
- R4: When a frame ends (`frm_end`), the descriptor is closed, `cur_ptr` advances by `DESC_STRIDE` and the next descriptor is fetched. If the closed descriptor had bit 30 of its first word set, `cur_ptr` returns to `list_base` instead.
- R5: A `frm_buf_end` during a frame advances the pointer and fetches the next descriptor. If that descriptor is DMA-owned, reception of the same frame continues (`frm_accept` high again).
- R6: A `frm_start` while suspended re-fetches the descriptor at the unchanged `cur_ptr`. If it is DMA-owned, the engine runs and accepts the frame. If not, `frm_drop` pulses for one cycle and the engine stays suspended.
- R7: A `poll_dmd` pulse causes a re-fetch at the unchanged `cur_ptr` only in the suspended state, and the engine runs if the descriptor is DMA-owned. In the stopped and running states a poll causes no fetch.
- R8: With `run_en` low, the engine enters stopped and sets `flag_stop` only when `mac_rx_en` is low. While `mac_rx_en` stays high, `proc_state` keeps its value and `flag_stop` stays low.
- R9: `flag_ru` and `flag_stop` stay set until a one-cycle pulse on `clr_ru` or `clr_stop` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Receive DMA run bit |
| mac_rx_en | input | 1 | MAC receiver enable level |
| poll_dmd | input | 1 | Receive poll-demand pulse |
| list_base | input | ADDR_W | Descriptor ring base address |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | ADDR_W | Address of descriptor being fetched |
| fetch_ack | input | 1 | Fetch response valid |
| fetch_data | input | 32 | Descriptor first word (bit 31 owner, bit 30 ring end) |
| frm_start | input | 1 | MAC signals a frame arriving |
| frm_buf_end | input | 1 | Current buffer exhausted before frame end |
| frm_end | input | 1 | Frame finished |
| frm_accept | output | 1 | Frame data is being written to the buffer |
| frm_drop | output | 1 | One-cycle pulse: a frame was discarded |
| proc_state | output | 2 | Process state: 0 stopped, 1 running, 2 suspended |
| cur_ptr | output | ADDR_W | Current list position |
| flag_ru | output | 1 | Sticky buffer-unavailable flag |
| flag_stop | output | 1 | Sticky process-stopped flag |
| clr_ru | input | 1 | Clear pulse for flag_ru |
| clr_stop | input | 1 | Clear pulse for flag_stop |

## Verification
The bench goes after the one-shot buffer-unavailable flag. It clears the flag while the engine is suspended and then sends frames and polls that fail again. A design that raises the flag on every failed fetch would set it a second time. The bench checks that re-fetches reuse the held list position, that the ring wraps on the marked descriptor, and that a buffer switch inside a frame keeps the frame. A design that reset the pointer or lost the frame would show a wrong address or a low accept. The bench also drops the run bit while the MAC is still enabled, where an early stop would report state 0 and raise the stopped flag too soon. It sends polls while stopped and running, which must produce no fetch.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        S_STOP,
        S_FETCH,
        S_IDLE,
        S_RECV,
        S_SUSP
    } rx_state_e;

    typedef enum logic [2:0] {
        C_START,
        C_NEXT,
        C_MID,
        C_SFRM,
        C_POLL
    } fetch_ctx_e;

    localparam int OWN_BIT      = 31;
    localparam int RING_END_BIT = 30;

    localparam logic [1:0] PS_STOP = 2'd0;
    localparam logic [1:0] PS_RUN  = 2'd1;
    localparam logic [1:0] PS_SUSP = 2'd2;

    typedef struct packed {
        logic dma_owned;
        logic ring_end;
    } desc_flags_t;

    function automatic desc_flags_t decode_desc(input logic [31:0] w);
        desc_flags_t f;
        f.dma_owned = w[OWN_BIT];
        f.ring_end  = w[RING_END_BIT];
        return f;
    endfunction

    function automatic logic ctx_from_suspend(input fetch_ctx_e c);
        return (c == C_SFRM) || (c == C_POLL);
    endfunction

    function automatic logic [1:0] state_code(input rx_state_e s, input fetch_ctx_e c);
        case (s)
            S_STOP:  return PS_STOP;
            S_SUSP:  return PS_SUSP;
            S_FETCH: return ctx_from_suspend(c) ? PS_SUSP : PS_RUN;
            default: return PS_RUN;
        endcase
    endfunction

endpackage

// File: rtl/rxd_ptr.sv
module rxd_ptr #(
    parameter int ADDR_W      = 16,
    parameter int DESC_STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic              cap,
    input  logic              cap_ring_end,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_STRIDE);

    logic ring_end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            ring_end_q <= 1'b0;
        end else begin
            if (cap)
                ring_end_q <= cap_ring_end;
            if (load)
                ptr <= base;
            else if (adv)
                ptr <= ring_end_q ? base : ptr + STEP;
        end
    end

    AST_NO_LOAD_AND_ADV: assert property (@(posedge clk) disable iff (rst)
        !(load && adv)); // R4
endmodule

// File: rtl/rxd_flags.sv
module rxd_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_ru,
    input  logic set_stop,
    input  logic clr_ru,
    input  logic clr_stop,
    output logic flag_ru,
    output logic flag_stop
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_ru   <= 1'b0;
            flag_stop <= 1'b0;
        end else begin
            if (set_ru)        flag_ru <= 1'b1;
            else if (clr_ru)   flag_ru <= 1'b0;
            if (set_stop)      flag_stop <= 1'b1;
            else if (clr_stop) flag_stop <= 1'b0;
        end
    end

    AST_RU_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_ru |=> flag_ru); // R9
endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
    import rxd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run_en,
    input  logic        mac_rx_en,
    input  logic        poll_dmd,
    input  logic        fetch_ack,
    input  logic [31:0] fetch_data,
    input  logic        frm_start,
    input  logic        frm_buf_end,
    input  logic        frm_end,
    output logic        fetch_req,
    output logic        frm_accept,
    output logic        frm_drop,
    output logic [1:0]  proc_state,
    output logic        ptr_load,
    output logic        ptr_adv,
    output logic        desc_cap,
    output logic        desc_ring_end,
    output logic        set_ru,
    output logic        set_stop
);
    rx_state_e   state, nxt;
    fetch_ctx_e  ctx, nctx;
    desc_flags_t dflags;
    logic        drop_now;

    assign dflags        = decode_desc(fetch_data);
    assign desc_ring_end = dflags.ring_end;

    always_comb begin
        nxt      = state;
        nctx     = ctx;
        ptr_load = 1'b0;
        ptr_adv  = 1'b0;
        desc_cap = 1'b0;
        set_ru   = 1'b0;
        set_stop = 1'b0;
        drop_now = 1'b0;
        case (state)
            S_STOP: begin
                if (run_en) begin
                    nxt      = S_FETCH;
                    nctx     = C_START;
                    ptr_load = 1'b1;
                end
            end
            S_FETCH: begin
                if (fetch_ack) begin
                    desc_cap = 1'b1;
                    if (dflags.dma_owned) begin
                        nxt = (ctx == C_MID || ctx == C_SFRM) ? S_RECV : S_IDLE;
                    end else begin
                        nxt = S_SUSP;
                        if (!ctx_from_suspend(ctx))
                            set_ru = 1'b1;
                        if (ctx == C_MID || ctx == C_SFRM)
                            drop_now = 1'b1;
                    end
                end
            end
            S_IDLE: begin
                if (!run_en) begin
                    if (!mac_rx_en) begin
                        nxt      = S_STOP;
                        set_stop = 1'b1;
                    end
                end else if (frm_start) begin
                    nxt = S_RECV;
                end
            end
            S_RECV: begin
                if (!run_en) begin
                    if (!mac_rx_en) begin
                        nxt      = S_STOP;
                        set_stop = 1'b1;
                    end
                end else if (frm_end) begin
                    nxt     = S_FETCH;
                    nctx    = C_NEXT;
                    ptr_adv = 1'b1;
                end else if (frm_buf_end) begin
                    nxt     = S_FETCH;
                    nctx    = C_MID;
                    ptr_adv = 1'b1;
                end
            end
            S_SUSP: begin
                if (!run_en) begin
                    if (!mac_rx_en) begin
                        nxt      = S_STOP;
                        set_stop = 1'b1;
                    end
                end else if (frm_start) begin
                    nxt  = S_FETCH;
                    nctx = C_SFRM;
                end else if (poll_dmd) begin
                    nxt  = S_FETCH;
                    nctx = C_POLL;
                end
            end
            default: nxt = S_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_STOP;
            ctx      <= C_START;
            frm_drop <= 1'b0;
        end else begin
            state    <= nxt;
            ctx      <= nctx;
            frm_drop <= drop_now;
        end
    end

    assign fetch_req  = (state == S_FETCH);
    assign frm_accept = (state == S_RECV);
    assign proc_state = state_code(state, ctx);

    AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> fetch_req); // R2
    AST_DROP_ONLY_SUSP: assert property (@(posedge clk) disable iff (rst)
        frm_drop |-> proc_state == PS_SUSP); // R6
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DESC_STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              mac_rx_en,
    input  logic              poll_dmd,
    input  logic [ADDR_W-1:0] list_base,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic [31:0]       fetch_data,
    input  logic              frm_start,
    input  logic              frm_buf_end,
    input  logic              frm_end,
    output logic              frm_accept,
    output logic              frm_drop,
    output logic [1:0]        proc_state,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              flag_ru,
    output logic              flag_stop,
    input  logic              clr_ru,
    input  logic              clr_stop
);
    logic ptr_load, ptr_adv, desc_cap, desc_ring_end, set_ru, set_stop;

    rxd_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .run_en       (run_en),
        .mac_rx_en    (mac_rx_en),
        .poll_dmd     (poll_dmd),
        .fetch_ack    (fetch_ack),
        .fetch_data   (fetch_data),
        .frm_start    (frm_start),
        .frm_buf_end  (frm_buf_end),
        .frm_end      (frm_end),
        .fetch_req    (fetch_req),
        .frm_accept   (frm_accept),
        .frm_drop     (frm_drop),
        .proc_state   (proc_state),
        .ptr_load     (ptr_load),
        .ptr_adv      (ptr_adv),
        .desc_cap     (desc_cap),
        .desc_ring_end(desc_ring_end),
        .set_ru       (set_ru),
        .set_stop     (set_stop)
    );

    rxd_ptr #(.ADDR_W(ADDR_W), .DESC_STRIDE(DESC_STRIDE)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .load        (ptr_load),
        .adv         (ptr_adv),
        .cap         (desc_cap),
        .cap_ring_end(desc_ring_end),
        .base        (list_base),
        .ptr         (cur_ptr)
    );

    rxd_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_ru   (set_ru),
        .set_stop (set_stop),
        .clr_ru   (clr_ru),
        .clr_stop (clr_stop),
        .flag_ru  (flag_ru),
        .flag_stop(flag_stop)
    );

    assign fetch_addr = cur_ptr;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        proc_state != 2'd3); // R1
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> $stable(fetch_addr)); // R2
    AST_RU_FROM_RUNNING: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_ru) |-> $past(proc_state) == PS_RUN); // R3
    AST_PTR_HELD_SUSP: assert property (@(posedge clk) disable iff (rst)
        (proc_state == PS_SUSP && $past(proc_state) == PS_SUSP) |-> $stable(cur_ptr)); // R6
    AST_POLL_IGNORED_RUN: assert property (@(posedge clk) disable iff (rst)
        (poll_dmd && proc_state == PS_RUN && !fetch_req && !frm_end && !frm_buf_end)
        |=> !fetch_req); // R7
    AST_STOP_NEEDS_MAC_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_stop) |-> (!$past(mac_rx_en) && proc_state == PS_STOP)); // R8
endmodule

// File: tb/tb_rxd_engine.sv
module tb_rxd_engine;
    localparam int AW     = 16;
    localparam int STRIDE = 16;
    localparam logic [AW-1:0] BASE = 16'h0100;

    logic clk = 0;
    logic rst = 1;
    logic run_en = 0, mac_rx_en = 0, poll_dmd = 0;
    logic [AW-1:0] list_base = BASE;
    logic fetch_req, fetch_ack = 0;
    logic [AW-1:0] fetch_addr;
    logic [31:0] fetch_data = '0;
    logic frm_start = 0, frm_buf_end = 0, frm_end = 0;
    logic frm_accept, frm_drop;
    logic [1:0] proc_state;
    logic [AW-1:0] cur_ptr;
    logic flag_ru, flag_stop;
    logic clr_ru = 0, clr_stop = 0;

    int checks = 0, fails = 0;
    int fetch_cnt = 0, drop_cnt = 0;
    logic [AW-1:0] last_addr = '0;
    logic own_bit [8];
    logic end_bit [8];

    always #10 clk = ~clk;

    rxd_engine #(.ADDR_W(AW), .DESC_STRIDE(STRIDE)) dut (.*);

    // descriptor responder and drop monitor
    initial begin
        forever begin
            @(negedge clk);
            if (frm_drop) drop_cnt++;
            if (fetch_req && !fetch_ack) begin
                int idx;
                idx = (int'(fetch_addr) - int'(BASE)) / STRIDE;
                fetch_data = '0;
                fetch_data[31] = own_bit[idx & 7];
                fetch_data[30] = end_bit[idx & 7];
                fetch_ack = 1;
                last_addr = fetch_addr;
                fetch_cnt++;
            end else begin
                fetch_ack = 0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1;
        @(negedge clk);
        s = 0;
    endtask

    function automatic logic [AW-1:0] addr_of(input int i);
        return BASE + AW'(i * STRIDE);
    endfunction

    task automatic t_reset();
        chk(proc_state == 0, "R1 state", proc_state, 0);
        chk(cur_ptr == 0, "R1 ptr", cur_ptr, 0);
        chk(!flag_ru && !flag_stop, "R1 flags", {flag_ru, flag_stop}, 0);
        chk(!fetch_req, "R1 req", fetch_req, 0);
    endtask

    task automatic t_poll_stopped();
        int f0;
        f0 = fetch_cnt;
        pulse(poll_dmd);
        tick(4);
        chk(fetch_cnt == f0, "R7 poll stopped", fetch_cnt, f0);
        chk(proc_state == 0, "R7 still stopped", proc_state, 0);
    endtask

    task automatic t_start();
        mac_rx_en = 1;
        run_en = 1;
        tick(5);
        chk(last_addr == BASE, "R2 first fetch", last_addr, BASE);
        chk(cur_ptr == BASE, "R2 ptr load", cur_ptr, BASE);
        chk(proc_state == 1, "R2 running", proc_state, 1);
    endtask

    task automatic frame_simple(input int next_idx, input string req);
        pulse(frm_start);
        tick(1);
        chk(frm_accept, {req, " accept"}, frm_accept, 1);
        pulse(frm_end);
        tick(4);
        chk(cur_ptr == addr_of(next_idx), {req, " ptr"}, cur_ptr, addr_of(next_idx));
        chk(last_addr == addr_of(next_idx), {req, " fetch addr"}, last_addr, addr_of(next_idx));
    endtask

    task automatic t_mid_frame();
        pulse(frm_start);
        pulse(frm_buf_end);
        tick(4);
        chk(cur_ptr == addr_of(2), "R5 ptr", cur_ptr, addr_of(2));
        chk(frm_accept, "R5 frame continues", frm_accept, 1);
        pulse(frm_end);
        tick(4);
        chk(cur_ptr == addr_of(3), "R5 after end", cur_ptr, addr_of(3));
    endtask

    task automatic t_suspend();
        own_bit[1] = 0;
        pulse(frm_start);
        pulse(frm_end);
        tick(4);
        chk(proc_state == 2, "R3 suspended", proc_state, 2);
        chk(flag_ru, "R3 ru set", flag_ru, 1);
        chk(cur_ptr == addr_of(1), "R3 ptr held", cur_ptr, addr_of(1));
    endtask

    task automatic t_susp_frame_drop();
        int d0, f0;
        pulse(clr_ru);
        tick(1);
        chk(!flag_ru, "R9 ru cleared", flag_ru, 0);
        d0 = drop_cnt;
        f0 = fetch_cnt;
        pulse(frm_start);
        tick(5);
        chk(fetch_cnt == f0 + 1, "R6 refetch", fetch_cnt, f0 + 1);
        chk(last_addr == addr_of(1), "R6 same addr", last_addr, addr_of(1));
        chk(drop_cnt == d0 + 1, "R6 drop", drop_cnt, d0 + 1);
        chk(proc_state == 2, "R6 still susp", proc_state, 2);
        chk(!flag_ru, "R3 no ru again", flag_ru, 0);
    endtask

    task automatic t_poll_susp();
        int f0;
        f0 = fetch_cnt;
        pulse(poll_dmd);
        tick(5);
        chk(fetch_cnt == f0 + 1, "R7 poll fetch", fetch_cnt, f0 + 1);
        chk(proc_state == 2 && !flag_ru, "R3 poll fail quiet", {proc_state, flag_ru}, 4);
        own_bit[1] = 1;
        pulse(poll_dmd);
        tick(5);
        chk(proc_state == 1, "R7 poll resumes", proc_state, 1);
        chk(cur_ptr == addr_of(1), "R7 ptr kept", cur_ptr, addr_of(1));
        f0 = fetch_cnt;
        pulse(poll_dmd);
        tick(4);
        chk(fetch_cnt == f0, "R7 poll running ignored", fetch_cnt, f0);
    endtask

    task automatic t_susp_frame_ok();
        own_bit[2] = 0;
        pulse(frm_start);
        pulse(frm_end);
        tick(4);
        chk(proc_state == 2 && flag_ru, "R3 ru again from run", {proc_state, flag_ru}, 5);
        own_bit[2] = 1;
        pulse(frm_start);
        tick(4);
        chk(proc_state == 1 && frm_accept, "R6 resume accept", {proc_state, frm_accept}, 3);
        pulse(frm_end);
        tick(4);
        chk(cur_ptr == addr_of(3), "R4 advance", cur_ptr, addr_of(3));
    endtask

    task automatic t_stop();
        run_en = 0;
        tick(4);
        chk(proc_state == 1, "R8 held by mac", proc_state, 1);
        chk(!flag_stop, "R8 no stop flag", flag_stop, 0);
        mac_rx_en = 0;
        tick(2);
        chk(proc_state == 0, "R8 stopped", proc_state, 0);
        chk(flag_stop, "R8 flag", flag_stop, 1);
        tick(3);
        chk(flag_stop, "R9 sticky", flag_stop, 1);
        pulse(clr_stop);
        tick(1);
        chk(!flag_stop, "R9 cleared", flag_stop, 0);
        mac_rx_en = 1;
        run_en = 1;
        tick(5);
        chk(cur_ptr == BASE && last_addr == BASE, "R2 restart at base", cur_ptr, BASE);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            own_bit[i] = 1;
            end_bit[i] = (i == 3);
        end
        tick(3);
        rst = 0;
        tick(1);
        t_reset();
        t_poll_stopped();
        t_start();
        frame_simple(1, "R4");
        t_mid_frame();
        frame_simple(0, "R4 wrap");
        t_suspend();
        t_susp_frame_drop();
        t_poll_susp();
        t_susp_frame_ok();
        t_stop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule